// File: doc/BRIEF.md
# Multiplexed LCD Backplane Sequencer

This block stores one bit per LCD element in a display memory of 4 rows by a parameterised number of columns (160 by default). From that memory it produces symbolic drive codes for a direct-drive multiplexed LCD. It does not produce voltages. A prescaler pulse, `slot_en_i`, advances the drive by one half-phase. Two half-phases make one time slot, and a frame holds one slot per active backplane. In the second half-phase of each slot every code is inverted, so the drive carries no net DC component.

The drive mode sets how many slots a frame holds: static (1), 1:2, 1:3 or 1:4. It also sets how the four physical backplane outputs repeat the active ones. In every mode the memory row with the same index as the current slot appears on the segment outputs. A write port stores single bits by row and column. The segment outputs only pick up new memory contents at the start of a slot, so no slot ever shows partly updated data.

Top module: `lcd_mux_drive`

## Requirements
- R1: After reset the memory is all zero, the mode is static, the drive is in slot 0 half-phase 0, every backplane code is 2'b01 and every segment output is 0.
- R2: Each cycle with `slot_en_i` high toggles the half-phase. A slot lasts two pulses, and the next slot begins on the pulse that ends half-phase 1.
- R3: The mode encoding is 0 static, 1 for 1:2, 2 for 1:3 and 3 for 1:4. A frame holds mode+1 slots, numbered from 0, and after the last slot the count wraps to 0.
- R4: Backplane j is selected when its mapped slot equals the current slot. The map is: 1:4 maps j to j; 1:3 maps 0,1,2,3 to 0,1,2,1; 1:2 maps j to j mod 2; static maps every backplane to slot 0.
- R5: Segment c shows the memory bit of the current slot's row at column c, XOR the half-phase. A stored 1 means the element is on.
- R6: A write stores `wr_data_i` at (`wr_row_i`, `wr_col_i`). The stored bit reaches the segments only when a later slot with that row begins. A write in the same cycle as a slot-starting pulse shows from the slot after that one.
- R7: A write with a column of `NUM_COLS` or more changes nothing.
- R8: `mode_i` is sampled only on the pulse that ends the last half-phase of a frame, and the new frame then starts in slot 0. A change in the middle of a frame does not alter that frame.
- R9: `bp_code_o[2j+1]` is the half-phase, common to all backplanes. `bp_code_o[2j]` is the selected flag of backplane j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Requested drive mode, applied at the next frame boundary |
| slot_en_i | input | 1 | Half-phase advance pulse from the prescaler |
| wr_en_i | input | 1 | Write strobe |
| wr_row_i | input | 2 | Write row |
| wr_col_i | input | 8 | Write column |
| wr_data_i | input | 1 | Write data, 1 = element on |
| bp_code_o | output | 8 | Per-backplane code {half-phase, selected} |
| seg_o | output | 160 | Per-segment on/off code, inverted in half-phase 1 |

## Verification
The assertions assume that `slot_en_i` is the only event that moves the drive. They also assume that writes and mode requests never disturb the visible outputs between pulses. The bench keeps within this by driving every input on the falling clock edge and raising `slot_en_i` for exactly one cycle at a time. Writes are issued only in cycles without a pulse, and `mode_i` is held steady except for deliberate changes partway through a frame. Memory patterns come from simple arithmetic on row and column. Every mode is swept for several frames, with each half-phase compared against a model built from the requirements.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam int unsigned NUM_BP = 4;
  localparam int unsigned ROW_W  = 2;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_MUX2   = 2'd1,
    MODE_MUX3   = 2'd2,
    MODE_MUX4   = 2'd3
  } lcd_mode_e;
endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lcd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slot_en_i,
  input  logic [1:0]       mode_i,
  output logic [ROW_W-1:0] slot_o,
  output logic [ROW_W-1:0] nxt_slot_o,
  output logic             phase_o,
  output logic             slot_adv_o,
  output lcd_mode_e        mode_o
);
  logic [ROW_W-1:0] slot_q;
  logic             phase_q;
  lcd_mode_e        mode_q;
  logic             last_slot;

  // last slot index equals the mode encoding
  assign last_slot  = (slot_q == ROW_W'(mode_q));
  assign nxt_slot_o = last_slot ? '0 : slot_q + 1'b1;
  assign slot_adv_o = slot_en_i & phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      phase_q <= 1'b0;
      mode_q  <= MODE_STATIC;
    end else if (slot_en_i) begin
      phase_q <= ~phase_q;
      if (phase_q) begin
        slot_q <= nxt_slot_o;
        if (last_slot) mode_q <= lcd_mode_e'(mode_i);
      end
    end
  end

  assign slot_o  = slot_q;
  assign phase_o = phase_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/lcd_disp_mem.sv
module lcd_disp_mem
  import lcd_pkg::*;
#(
  parameter int unsigned NUM_COLS = 160,
  localparam int unsigned COL_W = $clog2(NUM_COLS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ROW_W-1:0]    wr_row_i,
  input  logic [COL_W-1:0]    wr_col_i,
  input  logic                wr_data_i,
  input  logic                load_i,
  input  logic [ROW_W-1:0]    load_row_i,
  output logic [NUM_COLS-1:0] row_o
);
  logic [NUM_COLS-1:0] mem_q [NUM_BP];
  logic [NUM_COLS-1:0] row_q;
  logic                col_ok;

  assign col_ok = 32'(wr_col_i) < NUM_COLS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_BP; r++) mem_q[r] <= '0;
    end else if (wr_en_i && col_ok) begin
      mem_q[wr_row_i][wr_col_i] <= wr_data_i;
    end
  end

  // shadow row: captured only at slot start, from pre-write contents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (load_i) row_q <= mem_q[load_row_i];
  end

  assign row_o = row_q;
endmodule

// File: rtl/lcd_bp_map.sv
module lcd_bp_map
  import lcd_pkg::*;
(
  input  lcd_mode_e           mode_i,
  input  logic [ROW_W-1:0]    slot_i,
  input  logic                phase_i,
  output logic [2*NUM_BP-1:0] bp_code_o
);
  for (genvar j = 0; j < NUM_BP; j++) begin : g_bp
    logic [ROW_W-1:0] map_slot;
    always_comb begin
      unique case (mode_i)
        MODE_STATIC: map_slot = '0;
        MODE_MUX2:   map_slot = ROW_W'(j % 2);
        MODE_MUX3:   map_slot = (j == 3) ? ROW_W'(1) : ROW_W'(j);
        default:     map_slot = ROW_W'(j);
      endcase
    end
    assign bp_code_o[2*j+1] = phase_i;
    assign bp_code_o[2*j]   = (map_slot == slot_i);
  end
endmodule

// File: rtl/lcd_mux_drive.sv
module lcd_mux_drive
  import lcd_pkg::*;
#(
  parameter int unsigned NUM_COLS = 160,
  localparam int unsigned COL_W = $clog2(NUM_COLS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_i,
  input  logic                slot_en_i,
  input  logic                wr_en_i,
  input  logic [ROW_W-1:0]    wr_row_i,
  input  logic [COL_W-1:0]    wr_col_i,
  input  logic                wr_data_i,
  output logic [2*NUM_BP-1:0] bp_code_o,
  output logic [NUM_COLS-1:0] seg_o
);
  logic [ROW_W-1:0]    slot, nxt_slot;
  logic                phase, slot_adv;
  lcd_mode_e           act_mode;
  logic [NUM_COLS-1:0] row_bits;

  lcd_frame_timer u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_en_i  (slot_en_i),
    .mode_i     (mode_i),
    .slot_o     (slot),
    .nxt_slot_o (nxt_slot),
    .phase_o    (phase),
    .slot_adv_o (slot_adv),
    .mode_o     (act_mode)
  );

  lcd_disp_mem #(.NUM_COLS(NUM_COLS)) u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_row_i   (wr_row_i),
    .wr_col_i   (wr_col_i),
    .wr_data_i  (wr_data_i),
    .load_i     (slot_adv),
    .load_row_i (nxt_slot),
    .row_o      (row_bits)
  );

  lcd_bp_map u_map (
    .mode_i    (act_mode),
    .slot_i    (slot),
    .phase_i   (phase),
    .bp_code_o (bp_code_o)
  );

  assign seg_o = row_bits ^ {NUM_COLS{phase}};
endmodule

// File: rtl/lcd_mux_drive_chk.sv
module lcd_mux_drive_chk
  import lcd_pkg::*;
#(
  parameter int unsigned NUM_COLS = 160
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                slot_en_i,
  input logic [1:0]          act_mode_i,
  input logic [2*NUM_BP-1:0] bp_code_o,
  input logic [NUM_COLS-1:0] seg_o
);
  logic [NUM_BP-1:0] sel;
  for (genvar j = 0; j < NUM_BP; j++) begin : g_sel
    assign sel[j] = bp_code_o[2*j];
  end

  assert_phase_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_en_i |=> (bp_code_o[1] != $past(bp_code_o[1])));

  assert_hold_between_pulses_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_en_i |=> ($stable(seg_o) && $stable(bp_code_o)));

  assert_common_phase_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_code_o[1] == bp_code_o[3]) && (bp_code_o[1] == bp_code_o[5])
    && (bp_code_o[1] == bp_code_o[7]));

  assert_dc_balance_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_en_i && !bp_code_o[1]) |=> ((seg_o == ~$past(seg_o)) && (sel == $past(sel))));

  assert_map_static_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mode_i == 2'd0) |-> (sel == 4'b1111));

  assert_map_mux2_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mode_i == 2'd1) |-> ((sel[2] == sel[0]) && (sel[3] == sel[1]) && (sel[0] != sel[1])));

  assert_map_mux3_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mode_i == 2'd2) |-> ((sel[3] == sel[1]) && $onehot(sel[2:0])));

  assert_map_mux4_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mode_i == 2'd3) |-> $onehot(sel));
endmodule

bind lcd_mux_drive lcd_mux_drive_chk #(.NUM_COLS(NUM_COLS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .slot_en_i  (slot_en_i),
  .act_mode_i (act_mode),
  .bp_code_o  (bp_code_o),
  .seg_o      (seg_o)
);

// File: tb/lcd_mux_drive_tb.sv
`timescale 1ns/1ps
module lcd_mux_drive_tb;
  localparam int NC = 160;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic          slot_en_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_row_i = '0;
  logic [7:0]    wr_col_i = '0;
  logic          wr_data_i = 1'b0;
  logic [7:0]    bp_code_o;
  logic [NC-1:0] seg_o;

  lcd_mux_drive u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0, failures = 0;
  bit m_mem [4][NC];
  bit m_disp [NC];
  int m_slot = 0, m_phase = 0, m_mode = 0;

  function automatic int map_slot(int mode, int j);
    case (mode)
      0: return 0;
      1: return j % 2;
      2: return (j == 3) ? 1 : j;
      default: return j;
    endcase
  endfunction

  task automatic check_out(string rb, string rs);
    logic [7:0] eb;
    logic [NC-1:0] es;
    for (int j = 0; j < 4; j++) begin
      eb[2*j+1] = m_phase[0];
      eb[2*j]   = (map_slot(m_mode, j) == m_slot);
    end
    for (int c = 0; c < NC; c++) es[c] = m_disp[c] ^ m_phase[0];
    checks++;
    if (bp_code_o !== eb) begin
      failures++;
      $display("FAIL %s bp_code actual=%b expected=%b", rb, bp_code_o, eb);
    end
    checks++;
    if (seg_o !== es) begin
      failures++;
      $display("FAIL %s seg actual=%h expected=%h", rs, seg_o, es);
    end
  endtask

  task automatic tick();
    @(negedge clk_i) slot_en_i = 1'b1;
    @(negedge clk_i) slot_en_i = 1'b0;
    if (m_phase == 0) m_phase = 1;
    else begin
      m_phase = 0;
      if (m_slot == m_mode) begin
        m_mode = int'(mode_i);
        m_slot = 0;
      end else m_slot++;
      for (int c = 0; c < NC; c++) m_disp[c] = m_mem[m_slot][c];
    end
  endtask

  task automatic wr(int r, int c, bit d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_row_i = 2'(r); wr_col_i = 8'(c); wr_data_i = d;
    @(negedge clk_i) wr_en_i = 1'b0;
    if (c < NC) m_mem[r][c] = d;
  endtask

  task automatic fill(int seed);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < NC; c++)
        wr(r, c, ((c * 5 + r * 3 + seed) % 7) < 3);
  endtask

  task automatic run(int n, string rb, string rs);
    for (int i = 0; i < n; i++) begin
      tick();
      check_out(rb, rs);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_out("R1", "R1");

    // static mode: single slot frame, all backplanes selected (R3)
    run(4, "R3", "R2");

    for (int md = 3; md >= 0; md--) begin
      mode_i = 2'(md);
      run(2 * (m_mode + 1), "R8", "R8");  // finish current frame
      fill(md);
      check_out("R6", "R6");               // writes invisible mid-slot
      run(2 * 4 * 3, "R3/R4/R9", "R5");
    end

    // R7: out-of-range columns ignored
    mode_i = 2'd3;
    run(2, "R8", "R8");
    for (int c = NC; c < 256; c += 13) wr(0, c, 1'b1);
    wr(0, NC - 1, ~m_mem[0][NC-1]);
    run(16, "R7", "R7");

    // R6: write the row currently shown; only visible on a later slot
    while (!(m_slot == 2 && m_phase == 0)) tick();
    wr(2, 10, ~m_mem[2][10]);
    wr(2, 0, ~m_mem[2][0]);
    check_out("R6", "R6");
    run(1, "R6", "R6");
    run(8, "R6", "R6");

    // R8: mid-frame mode change keeps current frame
    while (!(m_slot == 1 && m_phase == 0)) tick();
    mode_i = 2'd1;
    run(8, "R8", "R8");
    mode_i = 2'd2;
    run(1, "R8", "R8");
    run(10, "R8", "R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule